// File: doc/BRIEF.md
# Memory Fence Ordering Controller

This block sits between an in-order issue stage and the memory and device interface, and holds back younger accesses until the older accesses a fence names have finished. It keeps one saturating outstanding-operation counter for each of four access classes: device input, device output, memory read and memory write. When a fence instruction word is handed over, the block decodes which younger classes must wait on which older classes. It then stalls requests in those younger classes until the counters of the older classes they depend on reach zero.

The issue stage presents each access with its class on a valid/ready pair. Completion comes back as one pulse per class. Fences arrive on their own valid/ready pair with the full 32-bit instruction word. Only one fence is held at a time. The store-ordering variant lets a younger load pass an older store. Every reserved encoding falls back to an ordinary fence. A build parameter can instead make every fence order all classes against all classes.

Top module: `fence_order_ctrl`

## Requirements
- R1: After reset no fence is held: `fence_active` is 0 and both `req_ready` and `fence_ready` are 1.
- R2: Class codes on `req_class` and bit positions in `done_pulse` and in the fence set fields are W=0, R=1, O=2, I=3. The fence word holds mode in [31:28], the older set in [27:24] and the younger set in [23:20], with opcode [6:0]=0001111 and [14:12]=000. With mode 0000, a request whose class is in the younger set is stalled (`req_ready`=0) while any class of the older set has a nonzero outstanding count.
- R3: A request whose class is outside the younger set of the held fence is never stalled, and with no fence held every request is accepted.
- R4: The held fence releases (`fence_active` falls) after the first cycle in which every required older class reads zero, and `fence_ready` is 1 in that cycle. While a fence is held and not drained, `fence_ready` is 0. A request accepted in the same cycle as a fence counts as older than it.
- R5: Mode 1000 with older set 0011 and younger set 0011 makes a younger read wait only on older reads, and a younger write wait on older reads and writes.
- R6: Mode 1000 with any other set pair behaves as mode 0000.
- R7: Any mode other than 0000 and 1000 behaves as mode 0000.
- R8: Bits [19:15] and [11:7] of the fence word have no effect.
- R9: A fence with an empty older set or an empty younger set is accepted, never stalls a request and never sets `fence_active`.
- R10: Each counter rises by one per accepted request and falls by one per completion pulse. A request and a completion in the same cycle leave it unchanged. It saturates at 2^CNT_W-1 and never goes below zero.
- R11: A word on the fence port whose opcode or [14:12] does not match is accepted and has no effect.
- R12: With CONSERVATIVE=1, every valid fence word orders all four classes against all four classes, whatever its mode and set fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_class | input | 2 | Access class code (W=0, R=1, O=2, I=3) |
| req_ready | output | 1 | Access may issue this cycle |
| done_pulse | input | 4 | One completion pulse per class, bit index = class code |
| fence_valid | input | 1 | Fence word present |
| fence_word | input | 32 | Fence instruction word |
| fence_ready | output | 1 | Fence accepted this cycle when valid |
| fence_active | output | 1 | A fence is currently held |

## Verification
A wrong counter value shows up as a read or write that issues too early, or as a fence that holds on after its last older completion. Either shows as a wrong `req_ready` or `fence_active` in the cycle right after the completion that should have drained the class. A wrongly decoded set shows in the very first cycle after the fence is accepted, as a request of the wrong class being stalled or let through. Saturation errors only appear after the counter limit has been exceeded, so they are driven past the limit and then drained one completion at a time.

// File: rtl/fence_pkg.sv
package fence_pkg;
  localparam int NCLS = 4;
  localparam logic [6:0] FENCE_OPC = 7'b0001111;
  localparam logic [3:0] MODE_NORMAL = 4'b0000;
  localparam logic [3:0] MODE_STORE_ORD = 4'b1000;
  localparam logic [3:0] SET_RW = 4'b0011;

  typedef logic [NCLS-1:0] cls_mask_t;

  // need[s] = older classes a younger access of class s must wait for
  typedef struct packed {
    logic                 valid;
    cls_mask_t [NCLS-1:0] need;
  } fence_req_t;

  function automatic cls_mask_t union_need(input cls_mask_t [NCLS-1:0] n);
    cls_mask_t u;
    u = '0;
    for (int s = 0; s < NCLS; s++) u = u | n[s];
    return u;
  endfunction

  function automatic logic waits_on(input cls_mask_t need_row, input cls_mask_t busy);
    return |(need_row & busy);
  endfunction
endpackage

// File: rtl/fence_decode.sv
module fence_decode
  import fence_pkg::*;
#(
  parameter bit CONSERVATIVE = 1'b0
) (
  input  logic [31:0] word,
  output fence_req_t  dreq
);
  logic [3:0] mode, older, younger;
  logic       is_fence, store_ord;

  assign mode     = word[31:28];
  assign older    = word[27:24];
  assign younger  = word[23:20];
  // bits [19:15] and [11:7] are deliberately unused
  assign is_fence = (word[6:0] == FENCE_OPC) && (word[14:12] == 3'b000);
  assign store_ord = (mode == MODE_STORE_ORD) && (older == SET_RW) && (younger == SET_RW);

  always_comb begin
    dreq.valid = is_fence;
    for (int s = 0; s < NCLS; s++) begin
      if (!is_fence)          dreq.need[s] = '0;
      else if (CONSERVATIVE)  dreq.need[s] = '1;
      else if (store_ord) begin
        if (s == 1)           dreq.need[s] = 4'b0010;
        else if (s == 0)      dreq.need[s] = 4'b0011;
        else                  dreq.need[s] = '0;
      end
      else                    dreq.need[s] = younger[s] ? older : '0;
    end
  end
endmodule

// File: rtl/class_counter.sv
module class_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    if (up && !dn)      return (c == CNT_MAX) ? c : c + 1'b1;
    else if (dn && !up) return (c == '0) ? c : c - 1'b1;
    else                return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= step_cnt(cnt, inc, dec);
  end

  assign busy = (cnt != '0);

  a_r10_same_cycle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(cnt));
  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && inc && !dec) |=> (cnt == CNT_MAX));
  a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && !inc) |=> (cnt == '0));
endmodule

// File: rtl/fence_gate.sv
module fence_gate
  import fence_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fence_valid,
  input  fence_req_t dreq,
  input  cls_mask_t  busy,
  output logic       fence_ready,
  output logic       fence_active,
  output cls_mask_t  cls_stall
);
  cls_mask_t [NCLS-1:0] need_q;
  logic drained, fence_fire, dreq_live;

  assign drained     = !waits_on(union_need(need_q), busy);
  assign fence_ready = !fence_active || drained;
  assign fence_fire  = fence_valid && fence_ready;
  assign dreq_live   = dreq.valid && (union_need(dreq.need) != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fence_active <= 1'b0;
      need_q       <= '0;
    end else if (fence_fire && dreq_live) begin
      fence_active <= 1'b1;
      need_q       <= dreq.need;
    end else if (fence_active && drained) begin
      fence_active <= 1'b0;
      need_q       <= '0;
    end
  end

  always_comb begin
    for (int s = 0; s < NCLS; s++)
      cls_stall[s] = fence_active && waits_on(need_q[s], busy);
  end

  a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_active && drained && !(fence_valid && dreq_live)) |=> !fence_active);
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_active && !drained) |=> fence_active);
  a_r9_empty_fence: assert property (@(posedge clk) disable iff (!rst_n)
    (fence_fire && !dreq_live && !fence_active) |=> !fence_active);
endmodule

// File: rtl/fence_order_ctrl.sv
module fence_order_ctrl
  import fence_pkg::*;
#(
  parameter int CNT_W        = 4,
  parameter bit CONSERVATIVE = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [1:0]  req_class,
  output logic        req_ready,
  input  logic [3:0]  done_pulse,
  input  logic        fence_valid,
  input  logic [31:0] fence_word,
  output logic        fence_ready,
  output logic        fence_active
);
  fence_req_t dreq;
  cls_mask_t  busy, cls_stall, issue_hit;

  fence_decode #(.CONSERVATIVE(CONSERVATIVE)) u_dec (
    .word (fence_word),
    .dreq (dreq)
  );

  assign req_ready = !cls_stall[req_class];

  generate
    for (genvar s = 0; s < NCLS; s++) begin : g_cls
      assign issue_hit[s] = req_valid && req_ready && (req_class == s);
      class_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue_hit[s]),
        .dec   (done_pulse[s]),
        .cnt   (),
        .busy  (busy[s])
      );
    end
  endgenerate

  fence_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .fence_valid  (fence_valid),
    .dreq         (dreq),
    .busy         (busy),
    .fence_ready  (fence_ready),
    .fence_active (fence_active),
    .cls_stall    (cls_stall)
  );

  a_r3_no_fence_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !fence_active |-> req_ready);
  a_r3_one_hot_issue: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(issue_hit));
endmodule

// File: tb/fence_order_ctrl_test.sv
`timescale 1ns/1ps
module fence_order_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, fence_valid = 1'b0;
  logic [1:0] req_class = '0;
  logic [3:0] done_pulse = '0;
  logic [31:0] fence_word = '0;
  logic [1:0] rr, fr, fa;

  always #2.5 clk = ~clk;

  fence_order_ctrl #(.CNT_W(4), .CONSERVATIVE(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_ready(rr[0]), .done_pulse(done_pulse), .fence_valid(fence_valid),
    .fence_word(fence_word), .fence_ready(fr[0]), .fence_active(fa[0]));
  fence_order_ctrl #(.CNT_W(4), .CONSERVATIVE(1'b1)) uut_c (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_ready(rr[1]), .done_pulse(done_pulse), .fence_valid(fence_valid),
    .fence_word(fence_word), .fence_ready(fr[1]), .fence_active(fa[1]));

  typedef struct { bit rr[2]; bit fr[2]; bit fa[2]; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // bench model
  int cnt[2][4];
  bit act[2];
  bit [3:0] nd[2][4];

  localparam bit [1:0] CW = 0, CR = 1, CO = 2, CI = 3;

  function automatic bit [31:0] mk(bit [3:0] m, bit [3:0] p, bit [3:0] s,
                                   bit [4:0] a = 0, bit [4:0] d = 0);
    return {m, p, s, a, 3'b000, d, 7'b0001111};
  endfunction

  function automatic bit [3:0] want(bit [31:0] w, int cons, int s);
    if (w[6:0] != 7'b0001111 || w[14:12] != 0) return 0;
    if (cons != 0) return 4'hF;
    if (w[31:28] == 4'h8 && w[27:24] == 4'h3 && w[23:20] == 4'h3)
      return (s == 1) ? 4'b0010 : ((s == 0) ? 4'b0011 : 4'b0000);
    return w[20 + s] ? w[27:24] : 4'b0000;
  endfunction

  function automatic bit [3:0] bmask(int m);
    bit [3:0] b;
    for (int s = 0; s < 4; s++) b[s] = (cnt[m][s] > 0);
    return b;
  endfunction

  task automatic chk(bit got, bit expv, string what, string tag);
    n_chk++;
    if (got !== expv) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b", tag, what, got, expv);
    end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      for (int m = 0; m < 2; m++) begin
        string t;
        t = (m == 0) ? e.tag : {e.tag, " uut_c R12"};
        chk(rr[m], e.rr[m], "req_ready", t);
        chk(fr[m], e.fr[m], "fence_ready", t);
        chk(fa[m], e.fa[m], "fence_active", t);
      end
    end
  end

  task automatic step(bit rv, bit [1:0] rc, bit fv, bit [31:0] w, bit [3:0] dn, string tag);
    exp_t e;
    bit drn[2];
    req_valid = rv; req_class = rc; fence_valid = fv; fence_word = w; done_pulse = dn;
    for (int m = 0; m < 2; m++) begin
      bit [3:0] b, u;
      b = bmask(m);
      u = nd[m][0] | nd[m][1] | nd[m][2] | nd[m][3];
      drn[m] = ((u & b) == 0);
      e.rr[m] = !(act[m] && ((nd[m][rc] & b) != 0));
      e.fr[m] = !act[m] || drn[m];
      e.fa[m] = act[m];
    end
    e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    @(posedge clk);
    #1;
    for (int m = 0; m < 2; m++) begin
      bit [3:0] nw;
      for (int s = 0; s < 4; s++) begin
        bit up;
        up = rv && e.rr[m] && (rc == s);
        if (up && !dn[s]) cnt[m][s] = (cnt[m][s] == 15) ? 15 : cnt[m][s] + 1;
        else if (dn[s] && !up) cnt[m][s] = (cnt[m][s] == 0) ? 0 : cnt[m][s] - 1;
      end
      nw = 0;
      for (int s = 0; s < 4; s++) nw = nw | want(w, m, s);
      if (fv && e.fr[m] && nw != 0) begin
        act[m] = 1;
        for (int s = 0; s < 4; s++) nd[m][s] = want(w, m, s);
      end else if (act[m] && drn[m]) begin
        act[m] = 0;
        for (int s = 0; s < 4; s++) nd[m][s] = 0;
      end
    end
  endtask

  task automatic iss(bit [1:0] c, string tag); step(1, c, 0, 0, 0, tag); endtask
  task automatic fen(bit [31:0] w, string tag); step(0, 0, 1, w, 0, tag); endtask
  task automatic dn(bit [3:0] d, bit [1:0] c, string tag); step(1, c, 0, 0, d, tag); endtask
  task automatic drain_all(string tag);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 4'hF, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      act[m] = 0;
      for (int s = 0; s < 4; s++) begin cnt[m][s] = 0; nd[m][s] = 0; end
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step(0, CR, 0, 0, 0, "R1 reset state");
    // normal fence: older W, younger R
    iss(CW, "R3 issue W"); iss(CW, "R3 issue W");
    fen(mk(4'h0, 4'b0001, 4'b0010), "R2 fence W->R");
    iss(CR, "R2 read stalled"); iss(CW, "R3 write passes"); iss(CO, "R3 out passes");
    dn(4'b0001, CR, "R2 still stalled"); dn(4'b0001, CR, "R2 stalled");
    step(0, CR, 1, mk(4'h0, 4'hF, 4'hF), 4'b0001, "R4 second fence waits");
    step(0, CR, 1, mk(4'h0, 4'hF, 4'hF), 0, "R4 release cycle");
    drain_all("R4 drain");
    // store-ordering fence
    iss(CW, "R5 W"); iss(CR, "R5 R");
    fen(mk(4'h8, 4'h3, 4'h3), "R5 tso fence");
    iss(CR, "R5 read waits read"); iss(CW, "R5 write waits");
    dn(4'b0010, CR, "R5 read done");
    iss(CR, "R5 read passes store"); iss(CW, "R5 write still waits");
    dn(4'b0011, CW, "R5 done"); iss(CW, "R5 write after release");
    drain_all("R5 drain");
    // mode 1000, non-RW sets
    iss(CW, "R6 W");
    fen(mk(4'h8, 4'h3, 4'h2), "R6 fence");
    iss(CR, "R6 read waits on write"); drain_all("R6 drain");
    // other mode
    iss(CW, "R7 W");
    fen(mk(4'h4, 4'h3, 4'h3), "R7 fence");
    iss(CR, "R7 read waits on write"); drain_all("R7 drain");
    // rs1/rd ignored
    iss(CI, "R8 I");
    fen(mk(4'h0, 4'b1000, 4'b0100, 5'h1F, 5'h15), "R8 fence");
    iss(CO, "R8 out waits"); iss(CR, "R8 read passes"); drain_all("R8 drain");
    // empty sets
    iss(CW, "R9 W");
    fen(mk(4'h0, 4'h0, 4'hF), "R9 empty older");
    iss(CR, "R9 no stall");
    fen(mk(4'h0, 4'hF, 4'h0), "R9 empty younger");
    iss(CW, "R9 no stall"); drain_all("R9 drain");
    // non-fence words
    iss(CW, "R11 W");
    fen(32'h0FF00013, "R11 other opcode");
    iss(CR, "R11 no effect");
    fen(mk(4'h0, 4'hF, 4'hF) | 32'h00001000, "R11 funct3 mismatch");
    iss(CR, "R11 no effect"); drain_all("R11 drain");
    // saturation and same-cycle
    for (int i = 0; i < 17; i++) iss(CW, "R10 fill");
    fen(mk(4'h0, 4'b0001, 4'b0010), "R10 fence");
    dn(4'b0001, CW, "R10 issue+done same cycle");
    for (int i = 0; i < 15; i++) dn(4'b0001, CR, "R10 drain to zero");
    iss(CR, "R10 read after drain");
    drain_all("end");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule